// File: doc/BRIEF.md
# Boundary-Scan Instruction Register and Decoder

This block holds the instruction of a boundary-scan test port and turns it into control for the rest of the test logic. An 8-bit shift stage sits between the serial test input and the serial test output during instruction scans. A shadow latch holds the active instruction and loads from the shift stage on the falling test-clock edge of the update state. A decoder turns the active instruction into four outputs. The first selects which data register goes into the scan path. The second sets the device mode: normal, test, or a modified test mode with the outputs tri-stated. The third tells the boundary register what to load on capture. The fourth names the run-test operation, if any.

The block also contains the 1-bit bypass register and the serial-output multiplexer. The multiplexer retimes the serial output and its enable onto the falling clock edge. The state machine that drives the strobes is outside the block. So are the boundary register, the control register and the signature and pattern logic, whose serial outputs arrive as inputs. Each strobe input is high for one state of the controller. It is driven just after the rising edge that entered that state.

Top module: `irdec_top`

## Requirements
- R1: While rstN is low, and on any falling tck edge with tlrState high, the active instruction becomes 11111111. That value decodes as bypass in normal mode, so dataSel=0, devMode=0, capSrc=0 and runOp=0.
- R2: A rising edge with captureIr high loads 10000001 into the shift stage. During the next eight shift-IR cycles tdo presents these bits lowest bit first: 1,0,0,0,0,0,0,1.
- R3: On each rising edge with shiftIr high, tdi enters bit 7 and every bit moves one place toward bit 0. After eight shifts the first bit sent is in bit 0, so an opcode is sent lowest bit first.
- R4: The active instruction changes only on a falling edge with updateIr high. Shifting a new opcode leaves all decoded outputs unchanged until that edge.
- R5: Bit 7 of the instruction has no effect on decoding.
- R6: The boundary register is selected (dataSel=1) for five opcodes, taking bits 6..0. 0000000 gives test mode with pin capture (devMode=1, capSrc=1). 0000010 gives normal mode with pin capture (0,1). 0001010 gives normal mode with hold (0,2). 0001011 gives test mode with hold (1,2). 0001100 gives normal mode with inverted capture (0,3). For all five, runOp=0.
- R7: Four opcodes select bypass (dataSel=0, capSrc=0) with special modes. 0000110 gives modified test mode with outputs off (devMode=2, runOp=0). 0000111 gives clamp in test mode (1,0). 0001001 gives test mode with the control-register operation (1,1). 0001101 gives test mode with output toggling (1,2).
- R8: 0001110 and 0001111 select the control register (dataSel=2) with capSrc=2 and runOp=0. The first is in normal mode (devMode=0) and the second in test mode (devMode=1).
- R9: Every other value of bits 6..0 decodes like 11111111: dataSel=0, devMode=0, capSrc=0, runOp=0.
- R10: When bypass is selected, the bypass bit loads 0 on a rising edge with captureDr high. On a rising edge with shiftDr high it loads tdi, so tdo shows 0 first and then each tdi bit one cycle later.
- R11: On each falling edge tdo is retimed from the shift stage's bit 0 while shiftIr is high. Otherwise it comes from the selected data register: bypass bit, bsrTdo or bcrTdo. tdoEn is retimed to shiftIr or shiftDr on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rstN | input | 1 | Power-up reset, active low, asynchronous |
| tdi | input | 1 | Serial test data in |
| tlrState | input | 1 | Controller is in the reset state |
| captureIr | input | 1 | Controller is in capture-IR |
| shiftIr | input | 1 | Controller is in shift-IR |
| updateIr | input | 1 | Controller is in update-IR |
| captureDr | input | 1 | Controller is in capture-DR |
| shiftDr | input | 1 | Controller is in shift-DR |
| bsrTdo | input | 1 | Serial output of the boundary register |
| bcrTdo | input | 1 | Serial output of the control register |
| tdo | output | 1 | Serial test data out, changes on falling edge |
| tdoEn | output | 1 | Serial output drive enable |
| dataSel | output | 2 | Selected data register: 0 bypass, 1 boundary, 2 control |
| devMode | output | 2 | 0 normal, 1 test, 2 test with outputs off |
| capSrc | output | 2 | Boundary capture: 0 none, 1 pins, 2 hold, 3 invert |
| runOp | output | 2 | Run-test operation: 0 none, 1 control-register op, 2 toggle |

## Verification
The decoded outputs change on the falling edge inside an update cycle, so they are sampled one time unit after that edge. tdo and tdoEn are also registered on the falling edge. They show the value a shift will consume at the next rising edge, so the captured pattern and the bypass zero appear in the first shift cycle. The bypass then delays each tdi bit by exactly one cycle. The bench changes strobes just after rising edges and samples just after falling edges, so each expected value is compared in the half-cycle in which it is due.

// File: rtl/irdec_pkg.sv
package irdec_pkg;
  localparam int IR_W = 8;
  localparam int OP_W = IR_W - 1;
  localparam logic [IR_W-1:0] IR_CAPTURE = 8'b1000_0001;
  localparam logic [IR_W-1:0] IR_RESET   = 8'b1111_1111;

  localparam logic [OP_W-1:0] OP_BSCAN   = 7'h00;
  localparam logic [OP_W-1:0] OP_SAMPLE  = 7'h02;
  localparam logic [OP_W-1:0] OP_HIGHZ   = 7'h06;
  localparam logic [OP_W-1:0] OP_CLAMP   = 7'h07;
  localparam logic [OP_W-1:0] OP_RUNT    = 7'h09;
  localparam logic [OP_W-1:0] OP_READN   = 7'h0A;
  localparam logic [OP_W-1:0] OP_READT   = 7'h0B;
  localparam logic [OP_W-1:0] OP_SELFT   = 7'h0C;
  localparam logic [OP_W-1:0] OP_TOGGLE  = 7'h0D;
  localparam logic [OP_W-1:0] OP_CTLN    = 7'h0E;
  localparam logic [OP_W-1:0] OP_CTLT    = 7'h0F;

  typedef enum logic [1:0] {DSEL_BYPASS = 2'd0, DSEL_BOUNDARY = 2'd1, DSEL_CONTROL = 2'd2} dsel_e;
  typedef enum logic [1:0] {MODE_NORMAL = 2'd0, MODE_TEST = 2'd1, MODE_HIGHZ = 2'd2} mode_e;
  typedef enum logic [1:0] {CAP_NONE = 2'd0, CAP_PINS = 2'd1, CAP_HOLD = 2'd2, CAP_INVERT = 2'd3} cap_e;
  typedef enum logic [1:0] {RUN_NONE = 2'd0, RUN_CTLREG = 2'd1, RUN_TOGGLE = 2'd2} run_e;

  typedef struct packed {
    dsel_e dsel;
    mode_e mode;
    cap_e  cap;
    run_e  run;
  } decode_t;

  typedef struct packed {
    logic  capIr;
    logic  shIr;
    logic  capDr;
    logic  shDr;
    dsel_e dsel;
  } strobe_t;
endpackage

// File: rtl/irdec_control.sv
module irdec_control
  import irdec_pkg::*;
(
  input  logic            tck,
  input  logic            rstN,
  input  logic            tlrState,
  input  logic            captureIr,
  input  logic            shiftIr,
  input  logic            updateIr,
  input  logic            captureDr,
  input  logic            shiftDr,
  input  logic [IR_W-1:0] irShiftVal,
  output strobe_t         strb,
  output decode_t         dec
);
  logic [IR_W-1:0] shadow;

  // active instruction, loaded on the falling edge
  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN)         shadow <= IR_RESET;
    else if (tlrState) shadow <= IR_RESET;
    else if (updateIr) shadow <= irShiftVal;
  end

  always_comb begin
    dec = '{dsel: DSEL_BYPASS, mode: MODE_NORMAL, cap: CAP_NONE, run: RUN_NONE};
    case (shadow[OP_W-1:0])
      OP_BSCAN:  dec = '{DSEL_BOUNDARY, MODE_TEST,   CAP_PINS,   RUN_NONE};
      OP_SAMPLE: dec = '{DSEL_BOUNDARY, MODE_NORMAL, CAP_PINS,   RUN_NONE};
      OP_HIGHZ:  dec = '{DSEL_BYPASS,   MODE_HIGHZ,  CAP_NONE,   RUN_NONE};
      OP_CLAMP:  dec = '{DSEL_BYPASS,   MODE_TEST,   CAP_NONE,   RUN_NONE};
      OP_RUNT:   dec = '{DSEL_BYPASS,   MODE_TEST,   CAP_NONE,   RUN_CTLREG};
      OP_READN:  dec = '{DSEL_BOUNDARY, MODE_NORMAL, CAP_HOLD,   RUN_NONE};
      OP_READT:  dec = '{DSEL_BOUNDARY, MODE_TEST,   CAP_HOLD,   RUN_NONE};
      OP_SELFT:  dec = '{DSEL_BOUNDARY, MODE_NORMAL, CAP_INVERT, RUN_NONE};
      OP_TOGGLE: dec = '{DSEL_BYPASS,   MODE_TEST,   CAP_NONE,   RUN_TOGGLE};
      OP_CTLN:   dec = '{DSEL_CONTROL,  MODE_NORMAL, CAP_HOLD,   RUN_NONE};
      OP_CTLT:   dec = '{DSEL_CONTROL,  MODE_TEST,   CAP_HOLD,   RUN_NONE};
      default:   ;
    endcase
  end

  assign strb = '{capIr: captureIr, shIr: shiftIr, capDr: captureDr, shDr: shiftDr, dsel: dec.dsel};

  // R1
  tlr_reset_chk: assert property (@(negedge tck) disable iff (!rstN)
    tlrState |=> shadow == IR_RESET);
  // R4
  update_load_chk: assert property (@(negedge tck) disable iff (!rstN)
    (!tlrState && updateIr) |=> shadow == $past(irShiftVal));
  // R4
  shadow_hold_chk: assert property (@(negedge tck) disable iff (!rstN)
    (!tlrState && !updateIr) |=> $stable(shadow));
  // R7
  highz_bypass_chk: assert property (@(negedge tck) disable iff (!rstN)
    (dec.mode == MODE_HIGHZ) |-> (dec.dsel == DSEL_BYPASS));
endmodule

// File: rtl/irdec_datapath.sv
module irdec_datapath
  import irdec_pkg::*;
(
  input  logic            tck,
  input  logic            rstN,
  input  logic            tdi,
  input  strobe_t         strb,
  input  logic            bsrTdo,
  input  logic            bcrTdo,
  output logic [IR_W-1:0] irShiftVal,
  output logic            tdo,
  output logic            tdoEn
);
  logic [IR_W-1:0] irSr;
  logic            bypassBit;
  logic            drOut;
  logic            serialOut;

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)           irSr <= IR_RESET;
    else if (strb.capIr) irSr <= IR_CAPTURE;
    else if (strb.shIr)  irSr <= {tdi, irSr[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) bypassBit <= 1'b0;
    else if (strb.dsel == DSEL_BYPASS) begin
      if (strb.capDr)     bypassBit <= 1'b0;
      else if (strb.shDr) bypassBit <= tdi;
    end
  end

  always_comb begin
    unique case (strb.dsel)
      DSEL_BOUNDARY: drOut = bsrTdo;
      DSEL_CONTROL:  drOut = bcrTdo;
      default:       drOut = bypassBit;
    endcase
    serialOut = strb.shIr ? irSr[0] : drOut;
  end

  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= serialOut;
      tdoEn <= strb.shIr | strb.shDr;
    end
  end

  assign irShiftVal = irSr;

  // R2
  capture_pattern_chk: assert property (@(posedge tck) disable iff (!rstN)
    strb.capIr |=> irSr == IR_CAPTURE);
  // R3
  shift_entry_chk: assert property (@(posedge tck) disable iff (!rstN)
    (strb.shIr && !strb.capIr) |=> irSr[IR_W-1] == $past(tdi));
  // R10
  bypass_zero_chk: assert property (@(posedge tck) disable iff (!rstN)
    (strb.capDr && strb.dsel == DSEL_BYPASS) |=> bypassBit == 1'b0);
endmodule

// File: rtl/irdec_top.sv
module irdec_top
  import irdec_pkg::*;
(
  input  logic       tck,
  input  logic       rstN,
  input  logic       tdi,
  input  logic       tlrState,
  input  logic       captureIr,
  input  logic       shiftIr,
  input  logic       updateIr,
  input  logic       captureDr,
  input  logic       shiftDr,
  input  logic       bsrTdo,
  input  logic       bcrTdo,
  output logic       tdo,
  output logic       tdoEn,
  output logic [1:0] dataSel,
  output logic [1:0] devMode,
  output logic [1:0] capSrc,
  output logic [1:0] runOp
);
  strobe_t         strb;
  decode_t         dec;
  logic [IR_W-1:0] irShiftVal;

  irdec_control u_ctrl (
    .tck(tck), .rstN(rstN), .tlrState(tlrState), .captureIr(captureIr),
    .shiftIr(shiftIr), .updateIr(updateIr), .captureDr(captureDr),
    .shiftDr(shiftDr), .irShiftVal(irShiftVal), .strb(strb), .dec(dec)
  );

  irdec_datapath u_dp (
    .tck(tck), .rstN(rstN), .tdi(tdi), .strb(strb), .bsrTdo(bsrTdo),
    .bcrTdo(bcrTdo), .irShiftVal(irShiftVal), .tdo(tdo), .tdoEn(tdoEn)
  );

  assign dataSel = dec.dsel;
  assign devMode = dec.mode;
  assign capSrc  = dec.cap;
  assign runOp   = dec.run;
endmodule

// File: tb/irdec_top_tb.sv
module irdec_top_tb;
  localparam int CLK_PERIOD = 10;

  logic tck = 1'b0;
  logic rstN, tdi, tlrState, captureIr, shiftIr, updateIr, captureDr, shiftDr, bsrTdo, bcrTdo;
  logic tdo, tdoEn;
  logic [1:0] dataSel, devMode, capSrc, runOp;
  int checks = 0;
  int failures = 0;
  logic [7:0] expDec;

  always #(CLK_PERIOD/2) tck = ~tck;

  irdec_top u_dut (
    .tck(tck), .rstN(rstN), .tdi(tdi), .tlrState(tlrState), .captureIr(captureIr),
    .shiftIr(shiftIr), .updateIr(updateIr), .captureDr(captureDr), .shiftDr(shiftDr),
    .bsrTdo(bsrTdo), .bcrTdo(bcrTdo), .tdo(tdo), .tdoEn(tdoEn), .dataSel(dataSel),
    .devMode(devMode), .capSrc(capSrc), .runOp(runOp)
  );

  // packed {dataSel, devMode, capSrc, runOp}
  function automatic logic [7:0] decodeRef(input logic [7:0] op);
    case (op[6:0])
      7'h00: return {2'd1, 2'd1, 2'd1, 2'd0};
      7'h02: return {2'd1, 2'd0, 2'd1, 2'd0};
      7'h06: return {2'd0, 2'd2, 2'd0, 2'd0};
      7'h07: return {2'd0, 2'd1, 2'd0, 2'd0};
      7'h09: return {2'd0, 2'd1, 2'd0, 2'd1};
      7'h0A: return {2'd1, 2'd0, 2'd2, 2'd0};
      7'h0B: return {2'd1, 2'd1, 2'd2, 2'd0};
      7'h0C: return {2'd1, 2'd0, 2'd3, 2'd0};
      7'h0D: return {2'd0, 2'd1, 2'd0, 2'd2};
      7'h0E: return {2'd2, 2'd0, 2'd2, 2'd0};
      7'h0F: return {2'd2, 2'd1, 2'd2, 2'd0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string reqOf(input logic [7:0] op);
    case (op[6:0])
      7'h00, 7'h02, 7'h0A, 7'h0B, 7'h0C: return "R6";
      7'h06, 7'h07, 7'h09, 7'h0D:        return "R7";
      7'h0E, 7'h0F:                      return "R8";
      default:                           return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic cIr, input logic sIr, input logic uIr,
                      input logic cDr, input logic sDr, input logic tlr, input logic d);
    @(posedge tck); #1;
    captureIr = cIr; shiftIr = sIr; updateIr = uIr;
    captureDr = cDr; shiftDr = sDr; tlrState = tlr; tdi = d;
    @(negedge tck); #1;
  endtask

  function automatic logic [7:0] outs();
    return {dataSel, devMode, capSrc, runOp};
  endfunction

  task automatic loadIr(input logic [7:0] op);
    step(1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) begin
      step(0, 1, 0, 0, 0, 0, op[i]);
      check("R2", tdo, (8'b1000_0001 >> i) & 1);
      check("R11", tdoEn, 1);
    end
    check("R4", outs(), expDec);
    step(0, 0, 1, 0, 0, 0, 0);
    expDec = decodeRef(op);
    check(op[7] ? "R5" : reqOf(op), outs(), expDec);
    check("R3", outs(), expDec);
    step(0, 0, 0, 0, 0, 0, 0);
    check("R11", tdoEn, 0);
  endtask

  task automatic scanDr(input int n);
    logic prevTdi;
    logic b, c, d;
    prevTdi = 1'b0;
    step(0, 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < n; i++) begin
      b = 1'($urandom); c = 1'($urandom); d = 1'($urandom);
      bsrTdo = b; bcrTdo = c;
      step(0, 0, 0, 0, 1, 0, d);
      if (expDec[7:6] == 2'd1)      check("R11", tdo, b);
      else if (expDec[7:6] == 2'd2) check("R11", tdo, c);
      else                          check("R10", tdo, prevTdi);
      prevTdi = d;
    end
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] op;
    logic [7:0] table_ops [12] = '{8'h00, 8'h02, 8'h06, 8'h07, 8'h09, 8'h0A,
                                   8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F, 8'h01};
    void'($urandom(32'd1234));
    rstN = 0; tdi = 0; tlrState = 0; captureIr = 0; shiftIr = 0; updateIr = 0;
    captureDr = 0; shiftDr = 0; bsrTdo = 0; bcrTdo = 0;
    expDec = 8'h00;
    #(CLK_PERIOD * 2 + 1);
    check("R1", outs(), 8'h00);
    check("R1", tdoEn, 0);
    rstN = 1;
    scanDr(4);
    foreach (table_ops[k]) begin
      loadIr(table_ops[k]);
      scanDr(5);
    end
    loadIr(8'h8B);
    loadIr(8'h80);
    loadIr(8'h10);
    loadIr(8'h7F);
    loadIr(8'h0F);
    step(0, 0, 0, 0, 0, 1, 0);
    expDec = 8'h00;
    check("R1", outs(), 8'h00);
    step(0, 0, 0, 0, 0, 0, 0);
    for (int r = 0; r < 30; r++) begin
      op = (r % 2 == 0) ? 8'($urandom_range(0, 15)) | {1'($urandom), 7'h00} : 8'($urandom);
      loadIr(op);
      scanDr(3);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule